// File: doc/BRIEF.md
# Speculative Load/Store Address Buffer

This block keeps memory accesses made speculatively by a ring of ordered execution stages until the oldest stage retires. It is a small, fully associative table. Each live entry holds one address. For every stage it also holds a load flag, a store flag and a stored byte. Stage age is always taken relative to the head pointer, so ordering stays correct when the ring wraps. The number of stages must be a power of two.

A load is answered one cycle after it is accepted. The answer is the value stored by the nearest stage that is the same age or older. If there is none, the answer is the backing-memory read data for the request address. Sometimes a store lands on an address that a younger stage has already loaded, with no store from a stage in between. In that case the buffer raises a violation naming the first such younger stage. In the same cycle it erases the flags of that stage and every stage up to the tail.

Stored bytes never reach memory early. A commit strobe starts a drain that visits every entry once, one per cycle. The drain writes out the head stage's stored bytes and clears the head stage's flags. An entry is free again as soon as none of its flags is set. A separate squash input discards a range of stages on request, for example after a wrong branch guess.

Controller states: `S_RUN` accepts requests, squashes and commits. `S_DRAIN` walks the entries. Transitions: `S_RUN` goes to `S_DRAIN` on `commit`. `S_DRAIN` goes to `S_RUN` after the cycle that handles the last entry.

Top module: `spec_addr_buf`

## Requirements
- R1: After reset no entry is in use; `req_ready` is 1 while idle in `S_RUN`, and `full`, `viol`, `load_valid` and `mem_wr_en` are 0.
- R2: An accepted load (`req_store`=0) whose address has no store from a stage of the same age or older drives `load_valid`=1 with `load_data` equal to `mem_rd_data` on the following cycle; `mem_rd_addr` equals `req_addr`.
- R3: An accepted load returns the byte stored by the youngest stage whose age (stage minus `head_ptr`, modulo the stage count) is not greater than the requesting stage's age.
- R4: A store from a younger stage is invisible to a load from an older stage at the same address.
- R5: An accepted store from stage i raises `viol` for one cycle, with `viol_stage`=j, the cycle after acceptance. Stage j is the first stage younger than i, up to the tail, that has a load flag on that address, with no store flag set on a stage strictly between i and j. The load and store flags of all stages from j to `tail_ptr` are cleared in every entry.
- R6: A store flag on a stage strictly between the storing stage and a younger loading stage suppresses the violation.
- R7: `commit` in `S_RUN` enters `S_DRAIN`, which lasts one cycle per entry with `req_ready`=0. For each entry holding a head-stage store, it writes that address and byte through `mem_wr_en`/`mem_wr_addr`/`mem_wr_data`. No other path writes memory.
- R8: The drain clears the head stage's flags in every entry, and an entry with no flag left can be allocated again.
- R9: `squash` in `S_RUN` clears the flags of every stage whose age lies from that of `squash_stage` to that of `tail_ptr`; older stages keep their data.
- R10: A request for an address with no entry, when every entry is in use, is not accepted (`req_ready`=0, `full`=1); a request to an address already held is still accepted, and at most one entry matches any address.
- R11: Age ordering is correct when the head pointer is not stage 0 and the live stages wrap past the top index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Load or store request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_stage | input | SW = log2(NSTG) | Stage issuing the request |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store byte |
| req_ready | output | 1 | Request accepted this cycle when high |
| full | output | 1 | New address refused because no entry is free |
| load_valid | output | 1 | Load answer valid |
| load_data | output | DW | Load answer |
| mem_rd_addr | output | AW | Backing memory read address |
| mem_rd_data | input | DW | Backing memory read data, combinational |
| head_ptr | input | SW | Oldest live stage |
| tail_ptr | input | SW | Youngest live stage |
| commit | input | 1 | Head stage retires; starts the drain |
| squash | input | 1 | Discard stages from `squash_stage` to tail |
| squash_stage | input | SW | First stage to discard |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write byte |
| viol | output | 1 | Ordering violation pulse |
| viol_stage | output | SW | First stage squashed by the violation |

## Verification
The bench builds the buffer with its defaults: four stages, four entries, 8-bit addresses and 8-bit data. With four entries, the refusal on a full table comes after four distinct addresses. A second test shows that an entry freed by a drain can be handed out again. With four stages, setting the head to 3 puts the youngest stages at numerically lower indices. This exposes any comparison made on raw stage numbers instead of head-relative age.

// File: rtl/sab_pkg.sv
package sab_pkg;
    typedef enum logic [0:0] {
        S_RUN   = 1'b0,
        S_DRAIN = 1'b1
    } sab_state_e;
endpackage

// File: rtl/sab_lookup.sv
module sab_lookup #(
    parameter int NENT = 4,
    parameter int AW   = 8,
    parameter int EW   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ent_addr [NENT],
    input  logic [NENT-1:0]   ent_used,
    input  logic [AW-1:0]     key,
    output logic              hit,
    output logic [EW-1:0]     hit_idx,
    output logic              free_any,
    output logic [EW-1:0]     free_idx
);
    logic [NENT-1:0] hit_vec;

    for (genvar e = 0; e < NENT; e++) begin : g_cmp
        assign hit_vec[e] = ent_used[e] && (ent_addr[e] == key);
    end

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int e = NENT - 1; e >= 0; e--) begin
            if (hit_vec[e]) begin
                hit     = 1'b1;
                hit_idx = EW'(e);
            end
            if (!ent_used[e]) begin
                free_any = 1'b1;
                free_idx = EW'(e);
            end
        end
    end

    // R10
    addr_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/sab_order.sv
module sab_order #(
    parameter int NSTG = 4,
    parameter int SW   = 2
) (
    input  logic [NSTG-1:0] ld_bits,
    input  logic [NSTG-1:0] st_bits,
    input  logic [SW-1:0]   head,
    input  logic [SW-1:0]   tail,
    input  logic [SW-1:0]   req_stage,
    output logic            fwd_found,
    output logic [SW-1:0]   fwd_stg,
    output logic            vio_found,
    output logic [SW-1:0]   vio_stg
);
    logic [SW-1:0] rel_req;
    logic [SW-1:0] rel_tail;

    assign rel_req  = req_stage - head;
    assign rel_tail = tail - head;

    always_comb begin
        logic          blocked;
        logic [SW-1:0] s;
        fwd_found = 1'b0;
        fwd_stg   = '0;
        vio_found = 1'b0;
        vio_stg   = '0;
        blocked   = 1'b0;
        s         = '0;
        for (int d = 0; d < NSTG; d++) begin
            s = head + SW'(d);
            // youngest storing stage not younger than the requester
            if (SW'(d) <= rel_req && st_bits[s]) begin
                fwd_found = 1'b1;
                fwd_stg   = s;
            end
            // first younger loader not shadowed by an intervening store
            if (SW'(d) > rel_req && SW'(d) <= rel_tail && !blocked && !vio_found) begin
                if (ld_bits[s]) begin
                    vio_found = 1'b1;
                    vio_stg   = s;
                end else if (st_bits[s]) begin
                    blocked = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spec_addr_buf.sv
module spec_addr_buf
    import sab_pkg::*;
#(
    parameter int NSTG = 4,
    parameter int NENT = 4,
    parameter int AW   = 8,
    parameter int DW   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_store,
    input  logic [$clog2(NSTG)-1:0]  req_stage,
    input  logic [AW-1:0]            req_addr,
    input  logic [DW-1:0]            req_wdata,
    output logic                     req_ready,
    output logic                     full,
    output logic                     load_valid,
    output logic [DW-1:0]            load_data,
    output logic [AW-1:0]            mem_rd_addr,
    input  logic [DW-1:0]            mem_rd_data,
    input  logic [$clog2(NSTG)-1:0]  head_ptr,
    input  logic [$clog2(NSTG)-1:0]  tail_ptr,
    input  logic                     commit,
    input  logic                     squash,
    input  logic [$clog2(NSTG)-1:0]  squash_stage,
    output logic                     mem_wr_en,
    output logic [AW-1:0]            mem_wr_addr,
    output logic [DW-1:0]            mem_wr_data,
    output logic                     viol,
    output logic [$clog2(NSTG)-1:0]  viol_stage
);
    localparam int SW = $clog2(NSTG);
    localparam int EW = (NENT > 1) ? $clog2(NENT) : 1;

    sab_state_e state, state_nxt;

    logic [NSTG-1:0] ld_q   [NENT];
    logic [NSTG-1:0] st_q   [NENT];
    logic [AW-1:0]   addr_q [NENT];
    logic [DW-1:0]   val_q  [NENT][NSTG];
    logic [NENT-1:0] used;
    logic [EW-1:0]   drain_idx;

    logic            hit, free_any;
    logic [EW-1:0]   hit_idx, free_idx, tgt;
    logic [NSTG-1:0] sel_ld, sel_st;
    logic            fwd_found, vio_found;
    logic [SW-1:0]   fwd_stg, vio_stg;
    logic            accept;
    logic            kill_en;
    logic [SW-1:0]   kill_from;
    logic [NSTG-1:0] kill_mask;

    for (genvar e = 0; e < NENT; e++) begin : g_used
        assign used[e] = (|ld_q[e]) || (|st_q[e]);
    end

    sab_lookup #(.NENT(NENT), .AW(AW), .EW(EW)) u_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .ent_addr (addr_q),
        .ent_used (used),
        .key      (req_addr),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    assign sel_ld = hit ? ld_q[hit_idx] : '0;
    assign sel_st = hit ? st_q[hit_idx] : '0;
    assign tgt    = hit ? hit_idx : free_idx;

    sab_order #(.NSTG(NSTG), .SW(SW)) u_order (
        .ld_bits   (sel_ld),
        .st_bits   (sel_st),
        .head      (head_ptr),
        .tail      (tail_ptr),
        .req_stage (req_stage),
        .fwd_found (fwd_found),
        .fwd_stg   (fwd_stg),
        .vio_found (vio_found),
        .vio_stg   (vio_stg)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_RUN;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_RUN:   if (commit) state_nxt = S_DRAIN;
            S_DRAIN: if (drain_idx == EW'(NENT - 1)) state_nxt = S_RUN;
            default: state_nxt = S_RUN;
        endcase
    end

    // state-driven outputs
    always_comb begin
        req_ready = 1'b0;
        full      = 1'b0;
        unique case (state)
            S_RUN: begin
                req_ready = !commit && !squash && (hit || free_any);
                full      = req_valid && !hit && !free_any;
            end
            S_DRAIN: begin
                req_ready = 1'b0;
                full      = 1'b0;
            end
            default: ;
        endcase
    end

    assign mem_rd_addr = req_addr;
    assign accept      = req_valid && req_ready;

    // stages to discard, measured by age from the head
    always_comb begin
        logic [SW-1:0] rf, rt, rs;
        kill_en   = (state == S_RUN && squash) || (accept && req_store && vio_found);
        kill_from = (state == S_RUN && squash) ? squash_stage : vio_stg;
        rf        = kill_from - head_ptr;
        rt        = tail_ptr - head_ptr;
        rs        = '0;
        for (int s = 0; s < NSTG; s++) begin
            rs           = SW'(s) - head_ptr;
            kill_mask[s] = kill_en && (rs >= rf) && (rs <= rt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < NENT; e++) begin
                ld_q[e] <= '0;
                st_q[e] <= '0;
            end
            drain_idx   <= '0;
            load_valid  <= 1'b0;
            load_data   <= '0;
            mem_wr_en   <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
            viol        <= 1'b0;
            viol_stage  <= '0;
        end else begin
            load_valid <= 1'b0;
            mem_wr_en  <= 1'b0;
            viol       <= 1'b0;
            if (kill_en) begin
                for (int e = 0; e < NENT; e++) begin
                    ld_q[e] <= ld_q[e] & ~kill_mask;
                    st_q[e] <= st_q[e] & ~kill_mask;
                end
            end
            if (accept) begin
                if (req_store) begin
                    st_q[tgt][req_stage] <= 1'b1;
                    if (vio_found) begin
                        viol       <= 1'b1;
                        viol_stage <= vio_stg;
                    end
                end else begin
                    ld_q[tgt][req_stage] <= 1'b1;
                    load_valid <= 1'b1;
                    load_data  <= fwd_found ? val_q[hit_idx][fwd_stg] : mem_rd_data;
                end
            end
            if (state == S_RUN && commit) begin
                drain_idx <= '0;
            end
            if (state == S_DRAIN) begin
                if (st_q[drain_idx][head_ptr]) begin
                    mem_wr_en   <= 1'b1;
                    mem_wr_addr <= addr_q[drain_idx];
                    mem_wr_data <= val_q[drain_idx][head_ptr];
                end
                ld_q[drain_idx][head_ptr] <= 1'b0;
                st_q[drain_idx][head_ptr] <= 1'b0;
                drain_idx <= drain_idx + 1'b1;
            end
        end
    end

    // address and data storage, no reset needed
    always_ff @(posedge clk) begin
        if (accept && !hit) addr_q[tgt] <= req_addr;
        if (accept && req_store) val_q[tgt][req_stage] <= req_wdata;
    end

    // R2
    load_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_store) |=> load_valid);

    // R7
    write_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(state) == S_DRAIN));

    // R5
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(req_valid && req_ready && req_store));

    // R7
    drain_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DRAIN) |-> !(req_valid && req_ready));
endmodule

// File: tb/test_spec_addr_buf.sv
`timescale 1ns/1ps
module test_spec_addr_buf;
    localparam int NSTG = 4;
    localparam int NENT = 4;
    localparam int AW   = 8;
    localparam int DW   = 8;
    localparam int SW   = $clog2(NSTG);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_store = 1'b0;
    logic [SW-1:0] req_stage = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, full, load_valid;
    logic [DW-1:0] load_data;
    logic [AW-1:0] mem_rd_addr;
    logic [DW-1:0] mem_rd_data;
    logic [SW-1:0] head_ptr = '0;
    logic [SW-1:0] tail_ptr = 2'd3;
    logic          commit = 1'b0;
    logic          squash = 1'b0;
    logic [SW-1:0] squash_stage = '0;
    logic          mem_wr_en;
    logic [AW-1:0] mem_wr_addr;
    logic [DW-1:0] mem_wr_data;
    logic          viol;
    logic [SW-1:0] viol_stage;

    int n_chk = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    bit done = 1'b0;

    logic [DW-1:0] mem [256];

    always #2 clk = ~clk;

    spec_addr_buf #(.NSTG(NSTG), .NENT(NENT), .AW(AW), .DW(DW)) i_spec_addr_buf (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_store(req_store), .req_stage(req_stage),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .full(full),
        .load_valid(load_valid), .load_data(load_data),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .head_ptr(head_ptr), .tail_ptr(tail_ptr),
        .commit(commit), .squash(squash), .squash_stage(squash_stage),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .viol(viol), .viol_stage(viol_stage)
    );

    // backing memory model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= DW'(i ^ 8'h5A);
        end else if (mem_wr_en) begin
            mem[mem_wr_addr] <= mem_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end
    assign mem_rd_data = mem[mem_rd_addr];

    function automatic int mv(input int a);
        return (a ^ 8'h5A) & 8'hFF;
    endfunction

    logic          cap_rdy, cap_full, cap_lv, cap_viol;
    logic [DW-1:0] cap_ld;
    logic [SW-1:0] cap_vst;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input bit st, input int stg, input int a, input int d);
        @(negedge clk);
        req_valid = 1'b1;
        req_store = st;
        req_stage = SW'(stg);
        req_addr  = AW'(a);
        req_wdata = DW'(d);
        #1;
        cap_rdy  = req_ready;
        cap_full = full;
        @(posedge clk);
        #1;
        cap_lv   = load_valid;
        cap_ld   = load_data;
        cap_viol = viol;
        cap_vst  = viol_stage;
        req_valid = 1'b0;
    endtask

    task automatic do_load(input int stg, input int a, input int exp, input string tag);
        drive(1'b0, stg, a, 0);
        check({tag, " ready"}, int'(cap_rdy), 1);
        check({tag, " valid"}, int'(cap_lv), 1);
        check({tag, " data"}, int'(cap_ld), exp);
    endtask

    task automatic do_store(input int stg, input int a, input int d,
                            input int ev, input int evs, input string tag);
        drive(1'b1, stg, a, d);
        check({tag, " ready"}, int'(cap_rdy), 1);
        check({tag, " viol"}, int'(cap_viol), ev);
        if (ev != 0) check({tag, " viol_stage"}, int'(cap_vst), evs);
    endtask

    task automatic do_squash(input int from);
        @(negedge clk);
        squash = 1'b1;
        squash_stage = SW'(from);
        @(posedge clk);
        #1;
        squash = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check("R1 ready", int'(req_ready), 1);
        check("R1 full", int'(full), 0);
        check("R1 viol", int'(viol), 0);
        check("R1 load_valid", int'(load_valid), 0);
        check("R1 mem_wr_en", int'(mem_wr_en), 0);
    endtask

    task automatic t_forward;
        head_ptr = 2'd0; tail_ptr = 2'd3;
        do_load(1, 10, mv(10), "R2 load from memory");
        check("R2 rd addr", int'(mem_rd_addr), 10);
        do_store(0, 20, 8'h11, 0, 0, "R3 store s0");
        do_store(2, 20, 8'h22, 0, 0, "R3 store s2");
        do_load(1, 20, 8'h11, "R3 nearest older s1");
        do_load(3, 20, 8'h22, "R3 nearest older s3");
        do_load(0, 20, 8'h11, "R3 own store s0");
        do_store(2, 21, 8'h2B, 0, 0, "R4 store s2");
        do_load(1, 21, mv(21), "R4 younger store hidden");
        do_squash(2);
        do_load(3, 20, 8'h11, "R9 s2 store dropped");
        do_load(2, 21, mv(21), "R9 s2 store a21 dropped");
        do_load(1, 20, 8'h11, "R9 older kept");
        do_squash(0);
    endtask

    task automatic t_violation;
        do_store(3, 31, 8'h3F, 0, 0, "R5 store s3");
        do_load(2, 30, mv(30), "R5 load s2");
        do_store(1, 30, 8'h33, 1, 2, "R5 late store s1");
        do_load(3, 31, mv(31), "R5 s3 squashed");
        check("R5 viol one cycle", int'(cap_viol), 0);
        do_load(2, 30, 8'h33, "R5 reload after squash");
        do_squash(0);
    endtask

    task automatic t_blocked;
        do_store(2, 40, 8'h44, 0, 0, "R6 store s2");
        do_load(3, 40, 8'h44, "R6 load s3");
        do_store(1, 40, 8'h41, 0, 0, "R6 shadowed store s1");
        do_load(3, 40, 8'h44, "R6 s3 still sees s2");
        do_squash(0);
    endtask

    task automatic t_full;
        for (int k = 0; k < NENT; k++) do_load(0, 50 + k, mv(50 + k), "R10 fill");
        drive(1'b0, 0, 54, 0);
        check("R10 new addr refused", int'(cap_rdy), 0);
        check("R10 full flag", int'(cap_full), 1);
        check("R10 no answer", int'(cap_lv), 0);
        do_store(0, 52, 8'h52, 0, 0, "R10 held addr accepted");
        do_squash(0);
        do_load(0, 54, mv(54), "R8 freed after squash");
        do_squash(0);
    endtask

    task automatic t_commit;
        int w0;
        do_store(0, 60, 8'h61, 0, 0, "R7 store s0 a60");
        do_store(0, 62, 8'h63, 0, 0, "R7 store s0 a62");
        do_store(1, 60, 8'h71, 0, 0, "R7 store s1 a60");
        do_load(0, 64, mv(64), "R7 load s0 a64");
        check("R7 no early write", int'(mem[60]), mv(60));
        w0 = wr_cnt;
        @(negedge clk);
        commit = 1'b1;
        @(posedge clk);
        #1;
        commit = 1'b0;
        check("R7 busy during drain", int'(req_ready), 0);
        repeat (NENT) @(posedge clk);
        #1;
        check("R7 back in run", int'(req_ready), 1);
        @(posedge clk);
        #1;
        check("R7 write count", wr_cnt - w0, 2);
        check("R7 mem a60", int'(mem[60]), 8'h61);
        check("R7 mem a62", int'(mem[62]), 8'h63);
        head_ptr = 2'd1; tail_ptr = 2'd0;
        do_load(1, 60, 8'h71, "R8 s1 keeps own store");
        do_load(2, 62, 8'h63, "R8 committed value from memory");
        do_load(0, 60, 8'h71, "R8 wrapped youngest s0");
        do_load(1, 80, mv(80), "R8 alloc a80");
        do_load(1, 81, mv(81), "R8 alloc a81 after free");
        do_squash(1);
    endtask

    task automatic t_wrap;
        head_ptr = 2'd3; tail_ptr = 2'd2;
        do_store(3, 70, 8'h7A, 0, 0, "R11 store head s3");
        do_load(0, 70, 8'h7A, "R11 s0 sees s3");
        do_store(1, 70, 8'h7B, 0, 0, "R11 store s1");
        do_load(2, 70, 8'h7B, "R11 s2 sees s1");
        do_store(0, 70, 8'h7C, 0, 0, "R11 shadowed by s1");
        do_load(2, 72, mv(72), "R11 load s2 a72");
        do_store(3, 72, 8'h7D, 1, 2, "R11 wrapped violation");
        do_load(2, 70, 8'h7B, "R11 older data kept");
        do_squash(3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        t_reset();
        t_forward();
        t_violation();
        t_blocked();
        t_full();
        t_commit();
        t_wrap();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule